// File: doc/BRIEF.md
# Transmit Descriptor Chain Gatherer

This block assembles outgoing frames that software has scattered across several memory buffers. Software builds a ring of 16-byte descriptors, each pointing at one fragment of a frame, and loads the address of the first descriptor into the block. A start pulse then begins a walk. For every descriptor the engine owns, it reads the fragment into an internal frame buffer and hands the descriptor back to software by rewriting its status word. When it reaches the final fragment of a frame, it streams the whole assembled frame out one byte at a time.

The walk ends at the first descriptor software still holds, or at a fragment that would push the frame past the buffer capacity; that descriptor is marked with an error. At the end the block pulses a walk-end strobe. It also pulses a transmit-done strobe, the interrupt request that also clears the start bit, but only if at least one frame left the block during that walk. Memory is reached through a single word-wide port that carries one request at a time. Reads complete when a read-valid strobe returns.

Top module: `txd_gather`

## Requirements
- R1: A list-load pulse while idle copies `list_addr` into both `list_head` and `cur_desc`. A list-load pulse while `busy` is high changes neither.
- R2: A start pulse while idle raises `busy` on the next cycle. Each descriptor is then read as four words at byte offsets 0, 4, 8 and 12: status, control, buffer address, next address. Only one read is in flight at a time, and the next step waits for `mem_rvalid`.
- R3: Bit 31 of the status word means the engine owns the descriptor. The walk stops at the first descriptor whose bit 31 is clear. That descriptor is not written, and `cur_desc` is left pointing at it.
- R4: The fragment length is bits 10:0 of the control word. The fragment is read as whole words from the word-aligned buffer address. Within each word, byte 0 is bits 7:0, and bytes are taken in ascending address order.
- R5: After a fragment is copied, the status word is written back to the descriptor's own address. Bit 31 is cleared and all other bits are unchanged.
- R6: Bit 30 of the control word marks the final fragment of a frame. At that fragment, the frame gathered so far is streamed out in order, with `out_last` on its final byte. The gathered length then returns to zero, and the walk continues at the next-address word.
- R7: If adding a fragment's length to the gathered length would exceed FRAME_MAX (2048 bytes) bytes, the walk stops. The status word is written back with bit 14 set and bit 31 kept. None of that fragment is copied, and the partial frame is dropped. A frame of exactly FRAME_MAX bytes is accepted.
- R8: When a walk ends, `busy` falls and `walk_end` pulses for one cycle. In the same cycle `tx_done` pulses, but only if at least one frame was streamed during that walk.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R10: After reset, `busy`, `out_valid` and `mem_req` are low, and `cur_desc` and `list_head` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_wr | input | 1 | Load pulse for the descriptor list address |
| list_addr | input | ADDR_W | Descriptor list address to load |
| start | input | 1 | Start-walk pulse |
| busy | output | 1 | High while a walk is in progress |
| list_head | output | ADDR_W | Loaded list head address |
| cur_desc | output | ADDR_W | Address of the current descriptor |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |
| walk_end | output | 1 | Pulse when a walk ends |
| tx_done | output | 1 | Pulse when a walk ends having sent at least one frame |

## Verification
A list-load request can arrive in the middle of a walk, so the load function and the walk can fall in the same cycle. The bench provokes this by pulsing `list_wr` with an unrelated address right after a start. It judges the result once `walk_end` has fired: `list_head` must still hold the original address, and `cur_desc` must name the descriptor where the walk stopped. Random `out_ready` stalls also make backpressure coincide with the final byte and with the end-of-walk strobes.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam int SIZE_W   = 11;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;
  localparam int LERR_BIT = 14;
  localparam logic [31:0] OWN_MASK  = 32'h1 << OWN_BIT;
  localparam logic [31:0] LERR_MASK = 32'h1 << LERR_BIT;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_BUF, S_STORE, S_ROUTE, S_EMIT, S_FIN
  } walk_st_t;
endpackage

// File: rtl/tdg_frame_buf.sv
module tdg_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/tdg_emitter.sv
module tdg_emitter #(
  parameter int IDX_W = 11,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [ACC_W-1:0] len,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             done,
  output logic [IDX_W-1:0] rd_idx
);
  typedef enum logic [1:0] {E_IDLE, E_LAT, E_SHOW} emit_st_t;
  emit_st_t est;

  always_ff @(posedge clk) begin
    if (rst) begin
      est       <= E_IDLE;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      done      <= 1'b0;
      rd_idx    <= '0;
    end else begin
      done <= 1'b0;
      unique case (est)
        E_IDLE: if (go) begin
          rd_idx <= '0;
          est    <= E_LAT;
        end
        E_LAT: begin
          out_valid <= 1'b1;
          out_last  <= (ACC_W'(rd_idx) + ACC_W'(1)) == len;
          est       <= E_SHOW;
        end
        E_SHOW: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (out_last) begin
            done <= 1'b1;
            est  <= E_IDLE;
          end else begin
            rd_idx <= rd_idx + IDX_W'(1);
            est    <= E_LAT;
          end
        end
        default: est <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_gather.sv
module txd_gather
  import tdg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int FRAME_MAX = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              list_wr,
  input  logic [ADDR_W-1:0] list_addr,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] list_head,
  output logic [ADDR_W-1:0] cur_desc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              walk_end,
  output logic              tx_done
);
  localparam int IDX_W = $clog2(FRAME_MAX);
  localparam int ACC_W = IDX_W + 1;
  localparam int SUM_W = ((ACC_W > SIZE_W) ? ACC_W : SIZE_W) + 1;

  walk_st_t           st;
  logic [1:0]         wsel, bsel;
  logic [31:0]        stat_w, ctl_w, bword;
  logic [ADDR_W-1:0]  baddr, nxt, boff;
  logic [ACC_W-1:0]   acc;
  logic [SIZE_W-1:0]  frag_left;
  logic               sent_any, emit_go, emit_done;
  logic [IDX_W-1:0]   rd_idx;
  logic [SIZE_W-1:0]  frag_len;
  logic [SUM_W-1:0]   frag_sum;

  assign frag_len = ctl_w[SIZE_W-1:0];
  assign frag_sum = SUM_W'(acc) + SUM_W'(frag_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  cur_desc <= '0;  list_head <= '0;
      busy <= 1'b0;  walk_end <= 1'b0;  tx_done <= 1'b0;
      mem_req <= 1'b0;  mem_we <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
      wsel <= '0;  bsel <= '0;  stat_w <= '0;  ctl_w <= '0;  bword <= '0;
      baddr <= '0;  nxt <= '0;  boff <= '0;  acc <= '0;  frag_left <= '0;
      sent_any <= 1'b0;  emit_go <= 1'b0;
    end else begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      walk_end <= 1'b0;
      tx_done  <= 1'b0;
      emit_go  <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (list_wr) begin
            list_head <= list_addr;
            cur_desc  <= list_addr;
          end
          if (start) begin
            busy     <= 1'b1;
            acc      <= '0;
            sent_any <= 1'b0;
            wsel     <= '0;
            mem_req  <= 1'b1;
            mem_addr <= list_wr ? list_addr : cur_desc;
            st       <= S_DESC;
          end
        end
        S_DESC: if (mem_rvalid) begin
          unique case (wsel)
            2'd0: begin
              stat_w <= mem_rdata;
              if (!mem_rdata[OWN_BIT]) st <= S_FIN;
              else begin
                wsel <= 2'd1;  mem_req <= 1'b1;  mem_addr <= cur_desc + ADDR_W'(4);
              end
            end
            2'd1: begin
              ctl_w <= mem_rdata;
              wsel <= 2'd2;  mem_req <= 1'b1;  mem_addr <= cur_desc + ADDR_W'(8);
            end
            2'd2: begin
              baddr <= mem_rdata[ADDR_W-1:0];
              wsel <= 2'd3;  mem_req <= 1'b1;  mem_addr <= cur_desc + ADDR_W'(12);
            end
            2'd3: begin
              nxt <= mem_rdata[ADDR_W-1:0];
              if (frag_sum > SUM_W'(FRAME_MAX)) begin
                mem_req <= 1'b1;  mem_we <= 1'b1;  mem_addr <= cur_desc;
                mem_wdata <= stat_w | LERR_MASK;
                st <= S_FIN;
              end else if (frag_len == '0) begin
                mem_req <= 1'b1;  mem_we <= 1'b1;  mem_addr <= cur_desc;
                mem_wdata <= stat_w & ~OWN_MASK;
                st <= S_ROUTE;
              end else begin
                frag_left <= frag_len;
                boff      <= baddr;
                mem_req   <= 1'b1;
                mem_addr  <= baddr;
                st        <= S_BUF;
              end
            end
            default: st <= S_FIN;
          endcase
        end
        S_BUF: if (mem_rvalid) begin
          bword <= mem_rdata;
          bsel  <= '0;
          st    <= S_STORE;
        end
        S_STORE: begin
          acc       <= acc + ACC_W'(1);
          frag_left <= frag_left - SIZE_W'(1);
          bsel      <= bsel + 2'd1;
          if (frag_left == SIZE_W'(1)) begin
            mem_req <= 1'b1;  mem_we <= 1'b1;  mem_addr <= cur_desc;
            mem_wdata <= stat_w & ~OWN_MASK;
            st <= S_ROUTE;
          end else if (bsel == 2'd3) begin
            boff     <= boff + ADDR_W'(4);
            mem_req  <= 1'b1;
            mem_addr <= boff + ADDR_W'(4);
            st       <= S_BUF;
          end
        end
        S_ROUTE: begin
          if (ctl_w[LAST_BIT] && acc != '0) begin
            emit_go <= 1'b1;
            st      <= S_EMIT;
          end else begin
            if (ctl_w[LAST_BIT]) acc <= '0;
            cur_desc <= nxt;  wsel <= '0;
            mem_req  <= 1'b1; mem_addr <= nxt;
            st       <= S_DESC;
          end
        end
        S_EMIT: if (emit_done) begin
          acc      <= '0;
          sent_any <= 1'b1;
          cur_desc <= nxt;  wsel <= '0;
          mem_req  <= 1'b1; mem_addr <= nxt;
          st       <= S_DESC;
        end
        S_FIN: begin
          busy     <= 1'b0;
          walk_end <= 1'b1;
          tx_done  <= sent_any;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  tdg_frame_buf #(.DEPTH(FRAME_MAX), .IDX_W(IDX_W)) u_fbuf (
    .clk   (clk),
    .we    (st == S_STORE),
    .waddr (acc[IDX_W-1:0]),
    .wdata (bword[8*bsel +: 8]),
    .raddr (rd_idx),
    .rdata (out_data)
  );

  tdg_emitter #(.IDX_W(IDX_W), .ACC_W(ACC_W)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .go        (emit_go),
    .len       (acc),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .done      (emit_done),
    .rd_idx    (rd_idx)
  );
endmodule

// File: rtl/tdg_chk.sv
module tdg_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        walk_end,
  input logic        tx_done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last
);
  // R8
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> walk_end);

  // R8
  done_scope_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> walk_end);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R5
  wb_val_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (!mem_wdata[31] || mem_wdata[14]));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !out_valid));
endmodule

bind txd_gather tdg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .walk_end  (walk_end),
  .tx_done   (tx_done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/sim_txd_gather.sv
module sim_txd_gather;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int FMAX = 2048;
  localparam int MEMW = 4096;
  localparam int DBASE = 32'h100;
  localparam int BBASE = 32'h1000;
  localparam int WD_CYCLES = 190000;

  logic clk, rst, list_wr, start, busy, mem_req, mem_we, mem_rvalid;
  logic out_valid, out_last, out_ready, walk_end, tx_done;
  logic [AW-1:0] list_addr, list_head, cur_desc, mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] out_data;

  txd_gather #(.ADDR_W(AW), .FRAME_MAX(FMAX)) u0 (
    .clk(clk), .rst(rst), .list_wr(list_wr), .list_addr(list_addr), .start(start),
    .busy(busy), .list_head(list_head), .cur_desc(cur_desc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .walk_end(walk_end), .tx_done(tx_done));

  int checks = 0, errors = 0;
  logic [31:0] mem [MEMW];
  logic [7:0] exp_b[$], got_b[$];
  bit exp_l[$], got_l[$];
  bit end_seen, done_seen, rnd_ready;
  int fsz[16];
  bit flast[16], fown[16];
  int nfrag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: single outstanding read, random latency
  logic rd_pend;
  int unsigned rd_idx, rd_lat;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) rd_pend <= 1'b0;
    else begin
      if (rd_pend) begin
        if (rd_lat == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[rd_idx];
          rd_pend    <= 1'b0;
        end else rd_lat <= rd_lat - 1;
      end
      if (mem_req) begin
        if (mem_we) mem[(mem_addr >> 2) % MEMW] <= mem_wdata;
        else begin
          rd_pend <= 1'b1;
          rd_idx  <= (mem_addr >> 2) % MEMW;
          rd_lat  <= $urandom_range(2, 0);
        end
      end
    end
  end

  // stream sink and strobe capture
  always @(negedge clk) begin
    out_ready <= 1'b1;
    if (rnd_ready) out_ready <= ($urandom_range(2, 0) != 0);
  end
  always @(negedge clk) begin
    #1;
    if (out_valid && out_ready) begin
      got_b.push_back(out_data);
      got_l.push_back(out_last);
    end
    if (walk_end) end_seen = 1'b1;
    if (tx_done) done_seen = 1'b1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int unsigned a);
    logic [31:0] w;
    w = mem[(a >> 2) % MEMW];
    return w[8*(a % 4) +: 8];
  endfunction

  task automatic run_chain(input string tag, input bit inject);
    int unsigned baddr[16];
    logic [31:0] st0[16];
    bit cleared[16], errf[16];
    logic [7:0] accq[$];
    int unsigned bp, i, end_i, frames, mism;
    bp = BBASE;
    for (int k = 0; k < nfrag; k++) begin
      baddr[k] = bp;
      for (int w = 0; w < (fsz[k] + 3) / 4; w++) mem[((bp >> 2) + w) % MEMW] = $urandom;
      bp += ((fsz[k] + 3) / 4) * 4 + 4;
      st0[k] = 32'h0000_0A05 | (fown[k] ? 32'h8000_0000 : 32'h0);
      mem[((DBASE + 16*k) >> 2)]     = st0[k];
      mem[((DBASE + 16*k) >> 2) + 1] = fsz[k] | (flast[k] << 30) |
                                       (((k == 0) || flast[(k == 0) ? 0 : k-1]) << 29);
      mem[((DBASE + 16*k) >> 2) + 2] = baddr[k];
      mem[((DBASE + 16*k) >> 2) + 3] = DBASE + 16*((k + 1) % nfrag);
      cleared[k] = 0; errf[k] = 0;
    end
    // expected walk
    exp_b.delete(); exp_l.delete(); accq.delete();
    i = 0; frames = 0;
    forever begin
      if (!fown[i] || cleared[i]) begin end_i = i; break; end
      if (accq.size() + fsz[i] > FMAX) begin errf[i] = 1; end_i = i; break; end
      for (int b = 0; b < fsz[i]; b++) accq.push_back(mbyte(baddr[i] + b));
      cleared[i] = 1;
      if (flast[i] && accq.size() > 0) begin
        for (int b = 0; b < accq.size(); b++) begin
          exp_b.push_back(accq[b]);
          exp_l.push_back(b == accq.size() - 1);
        end
        accq.delete();
        frames++;
      end else if (flast[i]) accq.delete();
      i = (i + 1) % nfrag;
    end
    got_b.delete(); got_l.delete();
    end_seen = 0; done_seen = 0;
    @(negedge clk); list_wr = 1; list_addr = DBASE;
    @(negedge clk); list_wr = 0;
    chk("R1", {tag, " head after load"}, list_head, DBASE);
    chk("R1", {tag, " current after load"}, cur_desc, DBASE);
    start = 1;
    @(negedge clk); start = 0;
    chk("R2", {tag, " busy after start"}, {31'b0, busy}, 32'd1);
    if (inject) begin
      list_wr = 1; list_addr = 32'h0000_2340;
      @(negedge clk); list_wr = 0;
    end
    while (!end_seen) @(negedge clk);
    @(negedge clk);
    chk("R8", {tag, " busy low after end"}, {31'b0, busy}, 32'd0);
    chk("R8", {tag, " tx_done"}, {31'b0, done_seen}, {31'b0, frames > 0});
    chk("R3", {tag, " stop descriptor"}, cur_desc, DBASE + 16*end_i);
    chk("R1", {tag, " head kept"}, list_head, DBASE);
    chk("R6", {tag, " byte count"}, got_b.size(), exp_b.size());
    mism = 32'hFFFF_FFFF;
    for (int b = 0; b < exp_b.size() && b < got_b.size(); b++)
      if (mism == 32'hFFFF_FFFF && (got_b[b] !== exp_b[b] || got_l[b] !== exp_l[b])) mism = b;
    chk("R4", {tag, " first bad byte or last flag index"}, mism, 32'hFFFF_FFFF);
    for (int k = 0; k < nfrag; k++) begin
      if (errf[k]) chk("R7", {tag, " error status"}, mem[(DBASE + 16*k) >> 2], st0[k] | 32'h4000);
      else if (cleared[k]) chk("R5", {tag, " released status"}, mem[(DBASE + 16*k) >> 2], st0[k] & 32'h7FFF_FFFF);
      else chk("R3", {tag, " untouched status"}, mem[(DBASE + 16*k) >> 2], st0[k]);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8 actual hung expected walk_end");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1; list_wr = 0; start = 0; list_addr = '0; rnd_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10", "busy", {31'b0, busy}, 32'd0);
    chk("R10", "out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10", "mem_req", {31'b0, mem_req}, 32'd0);
    chk("R10", "cur_desc", cur_desc, 32'd0);
    chk("R10", "list_head", list_head, 32'd0);

    // single fragment frame (R4, R6)
    nfrag = 1; fsz[0] = 5; flast[0] = 1; fown[0] = 1;
    run_chain("one", 0);
    // head not owned (R3, R8)
    nfrag = 2; fsz[0] = 8; flast[0] = 1; fown[0] = 0; fsz[1] = 8; flast[1] = 1; fown[1] = 1;
    run_chain("unowned", 0);
    // fragment without end marker (R5, R8 no tx_done)
    nfrag = 2; fsz[0] = 9; flast[0] = 0; fown[0] = 1; fsz[1] = 4; flast[1] = 1; fown[1] = 0;
    run_chain("partial", 0);
    // exactly FRAME_MAX bytes (R7 boundary)
    nfrag = 2; fsz[0] = 2000; flast[0] = 0; fown[0] = 1; fsz[1] = 48; flast[1] = 1; fown[1] = 1;
    run_chain("full", 0);
    // oversize after a sent frame, with list load mid-walk (R7, R1)
    nfrag = 3; fsz[0] = 10; flast[0] = 1; fown[0] = 1; fsz[1] = 2000; flast[1] = 0; fown[1] = 1;
    fsz[2] = 100; flast[2] = 1; fown[2] = 1;
    rnd_ready = 1;
    run_chain("oversize", 1);
    // oversize with nothing sent (R7, R8)
    nfrag = 2; fsz[0] = 2040; flast[0] = 0; fown[0] = 1; fsz[1] = 9; flast[1] = 1; fown[1] = 1;
    run_chain("overnone", 0);
    // random chains with backpressure (R2, R4, R6, R9)
    for (int r = 0; r < 10; r++) begin
      nfrag = $urandom_range(8, 2);
      for (int k = 0; k < nfrag; k++) begin
        fsz[k] = $urandom_range(150, 1);
        flast[k] = $urandom_range(1, 0);
        fown[k] = 1;
      end
      flast[nfrag-1] = 1;
      if ($urandom_range(3, 0) == 0) fown[$urandom_range(nfrag-1, 1)] = 0;
      run_chain("random", r[0]);
    end
    summary();
    $finish;
  end
endmodule